// File: doc/BRIEF.md
# Configurable Output Macrocell

This block models one output macrocell of a small programmable logic array. A group of product terms arrives from the AND array. The macrocell ORs them, applies a programmable polarity through an XOR stage, and then either passes the result straight to the pin or captures it in a D flip-flop. It also decides when the pin driver is enabled and what signal is fed back into the array.

Four static configuration bits select the behaviour: a sync-select bit, a shared enable-control bit, a per-cell enable-control bit and a polarity bit. Five of the eight combinations are legal operating modes. These modes change the output path, the source of the output enable and the feedback source. The three remaining combinations park the cell with its driver off. A synchronous reset clears the flip-flop.

Top module: `olmc_cell`

## Requirements
- R1: With cfg_syn=1, cfg_ac0=0, cfg_ac1=0 (dedicated output), pin_oe is 1, pin_drv equals (OR of all pt bits) XOR cfg_pol, and fb is 0.
- R2: With cfg_syn=1, cfg_ac0=0, cfg_ac1=1 (dedicated input), pin_oe is 0, pin_drv is 0, and fb equals pin_in.
- R3: With cfg_syn=1, cfg_ac0=1, cfg_ac1=1 (complex combinational), pin_oe equals pt[0], pin_drv equals (OR of pt[NUM_PT-1:1]) XOR cfg_pol, and fb equals pin_in.
- R4: With cfg_syn=0, cfg_ac0=1, cfg_ac1=0 (registered), each rising clock edge loads the register with (OR of all pt bits) XOR cfg_pol. In this mode pin_drv is the inverted register value, pin_oe equals glob_oe, and fb is the register value.
- R5: With cfg_syn=0, cfg_ac0=1, cfg_ac1=1 (combinational cell in a registered device), pin_oe equals pt[0], pin_drv equals (OR of pt[NUM_PT-1:1]) XOR cfg_pol, and fb equals pin_in.
- R6: In every mode other than registered, the register keeps its value across clock edges. This shows in fb once the cell returns to registered mode.
- R7: When rst is 1 at a rising clock edge, the register becomes 0 in any mode.
- R8: The combinations cfg_syn=0 with cfg_ac0=0, and cfg_syn=1 with cfg_ac0=1 and cfg_ac1=0, are not legal modes. For these, pin_oe, pin_drv and fb are all 0.
- R9: glob_oe has no effect on pin_oe outside registered mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock, rising edge |
| rst | input | 1 | Synchronous clear of the register |
| pt | input | NUM_PT | Product terms from the AND array |
| glob_oe | input | 1 | Output enable shared by all macrocells |
| pin_in | input | 1 | Value currently present on the pin |
| cfg_syn | input | 1 | 0 selects the registered family of modes, 1 the combinational family |
| cfg_ac0 | input | 1 | Shared enable/feedback control bit |
| cfg_ac1 | input | 1 | Per-cell enable/feedback control bit |
| cfg_pol | input | 1 | Output polarity, 1 inverts the OR sum |
| pin_drv | output | 1 | Value the pin driver puts out |
| pin_oe | output | 1 | Tri-state enable of the pin driver |
| fb | output | 1 | Feedback signal returned to the array |

## Verification
Random product-term patterns are applied with both polarities in all eight configuration codes, so the sum, XOR and mode decode are exercised against each other. Patterns where only pt[0] is set separate the two complex modes, which use pt[0] as the enable and leave it out of the sum, from the modes that sum every term. Sequences that load the register, leave registered mode, toggle the terms and then return show that the register holds. Pulses of rst show that the register clears. Toggling glob_oe and pin_in in the non-registered modes shows that each one reaches the output only in the mode that uses it.

// File: rtl/olmc_cell.sv
module olmc_cell #(
  parameter int NUM_PT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_PT-1:0] pt,
  input  logic              glob_oe,
  input  logic              pin_in,
  input  logic              cfg_syn,
  input  logic              cfg_ac0,
  input  logic              cfg_ac1,
  input  logic              cfg_pol,
  output logic              pin_drv,
  output logic              pin_oe,
  output logic              fb
);
  logic q;

  wire m_out  = cfg_syn & ~cfg_ac0 & ~cfg_ac1;
  wire m_in   = cfg_syn & ~cfg_ac0 &  cfg_ac1;
  wire m_cplx = cfg_ac0 & cfg_ac1;
  wire m_reg  = ~cfg_syn & cfg_ac0 & ~cfg_ac1;

  wire x_all = (|pt) ^ cfg_pol;
  wire x_up  = (|pt[NUM_PT-1:1]) ^ cfg_pol;

  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (m_reg) q <= x_all;
  end

  always_comb begin
    pin_drv = 1'b0;
    pin_oe  = 1'b0;
    fb      = 1'b0;
    if (m_out) begin
      pin_drv = x_all;
      pin_oe  = 1'b1;
    end else if (m_in) begin
      fb = pin_in;
    end else if (m_cplx) begin
      pin_drv = x_up;
      pin_oe  = pt[0];
      fb      = pin_in;
    end else if (m_reg) begin
      pin_drv = ~q;
      pin_oe  = glob_oe;
      fb      = q;
    end
  end
endmodule

// File: rtl/olmc_cell_chk.sv
module olmc_cell_chk #(
  parameter int NUM_PT = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_PT-1:0] pt,
  input logic              glob_oe,
  input logic              pin_in,
  input logic              cfg_syn,
  input logic              cfg_ac0,
  input logic              cfg_ac1,
  input logic              cfg_pol,
  input logic              pin_drv,
  input logic              pin_oe,
  input logic              fb,
  input logic              q
);
  wire c_reg  = ~cfg_syn & cfg_ac0 & ~cfg_ac1;
  wire c_in   = cfg_syn & ~cfg_ac0 & cfg_ac1;
  wire c_out  = cfg_syn & ~cfg_ac0 & ~cfg_ac1;
  wire c_cplx = cfg_ac0 & cfg_ac1;
  wire c_bad  = (~cfg_syn & ~cfg_ac0) | (cfg_syn & cfg_ac0 & ~cfg_ac1);

  AST_OUT_ENABLED:  assert property (@(posedge clk) disable iff (rst) c_out |-> (pin_oe && !fb)); // R1
  AST_INPUT_QUIET:  assert property (@(posedge clk) disable iff (rst) c_in |-> (!pin_oe && fb == pin_in)); // R2
  AST_CPLX_OE:      assert property (@(posedge clk) disable iff (rst) c_cplx |-> (pin_oe == pt[0] && fb == pin_in)); // R3
  AST_REG_LOAD:     assert property (@(posedge clk) disable iff (rst) c_reg |=> (q == $past((|pt) ^ cfg_pol))); // R4
  AST_REG_PIN:      assert property (@(posedge clk) disable iff (rst) c_reg |-> (pin_drv != fb && pin_oe == glob_oe)); // R4
  AST_REG_HOLD:     assert property (@(posedge clk) disable iff (rst) !c_reg |=> $stable(q)); // R6
  AST_RESET_CLEAR:  assert property (@(posedge clk) rst |=> !q); // R7
  AST_ILLEGAL_OFF:  assert property (@(posedge clk) disable iff (rst) c_bad |-> (!pin_oe && !pin_drv && !fb)); // R8
endmodule

bind olmc_cell olmc_cell_chk #(.NUM_PT(NUM_PT)) u_chk (
  .clk(clk), .rst(rst), .pt(pt), .glob_oe(glob_oe), .pin_in(pin_in),
  .cfg_syn(cfg_syn), .cfg_ac0(cfg_ac0), .cfg_ac1(cfg_ac1), .cfg_pol(cfg_pol),
  .pin_drv(pin_drv), .pin_oe(pin_oe), .fb(fb), .q(q)
);

// File: tb/olmc_cell_bench.sv
`timescale 1ns/1ps
module olmc_cell_bench;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] pt = '0;
  logic glob_oe = 1'b0, pin_in = 1'b0;
  logic cfg_syn = 1'b0, cfg_ac0 = 1'b1, cfg_ac1 = 1'b0, cfg_pol = 1'b0;
  logic pin_drv, pin_oe, fb;
  logic mq = 1'b0;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  olmc_cell #(.NUM_PT(N)) u_olmc_cell (
    .clk(clk), .rst(rst), .pt(pt), .glob_oe(glob_oe), .pin_in(pin_in),
    .cfg_syn(cfg_syn), .cfg_ac0(cfg_ac0), .cfg_ac1(cfg_ac1), .cfg_pol(cfg_pol),
    .pin_drv(pin_drv), .pin_oe(pin_oe), .fb(fb)
  );

  // expected {pin_drv, pin_oe, fb}
  function automatic logic [2:0] expect_out(logic s, logic a0, logic a1, logic pol,
                                            logic [N-1:0] p, logic goe, logic pin, logic qv);
    logic xa, xu;
    xa = (|p) ^ pol;
    xu = (|p[N-1:1]) ^ pol;
    if (s && !a0 && !a1) return {xa, 1'b1, 1'b0};
    if (s && !a0 && a1)  return {1'b0, 1'b0, pin};
    if (a0 && a1)        return {xu, p[0], pin};
    if (!s && a0 && !a1) return {~qv, goe, qv};
    return 3'b000;
  endfunction

  function automatic string mode_tag(logic s, logic a0, logic a1);
    if (s && !a0 && !a1) return "R1";
    if (s && !a0 && a1)  return "R2";
    if (s && a0 && a1)   return "R3";
    if (!s && a0 && !a1) return "R4";
    if (!s && a0 && a1)  return "R5";
    return "R8";
  endfunction

  task automatic step(logic s, logic a0, logic a1, logic pol, logic [N-1:0] p,
                      logic goe, logic pin, logic r, string tag);
    logic [2:0] exp_v, act;
    @(negedge clk);
    cfg_syn = s; cfg_ac0 = a0; cfg_ac1 = a1; cfg_pol = pol;
    pt = p; glob_oe = goe; pin_in = pin; rst = r;
    #0.5;
    exp_v = expect_out(s, a0, a1, pol, p, goe, pin, mq);
    act = {pin_drv, pin_oe, fb};
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s: {drv,oe,fb} actual=%b expected=%b", (tag == "") ? mode_tag(s, a0, a1) : tag, act, exp_v);
    end
    @(posedge clk);
    if (r) mq = 1'b0;
    else if (!s && a0 && !a1) mq = (|p) ^ pol;
  endtask

  initial begin
    #500000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R7 reset state: registered mode, register cleared
    step(0, 1, 0, 0, 8'h00, 1, 0, 1, "R7");
    step(0, 1, 0, 0, 8'h00, 1, 0, 0, "R7");
    // R4 load 1 then 0, with polarity
    step(0, 1, 0, 0, 8'h10, 1, 0, 0, "R4");
    step(0, 1, 0, 1, 8'h10, 0, 0, 0, "R4");
    step(0, 1, 0, 1, 8'h00, 1, 0, 0, "R4");
    // R6 hold across other modes while pt toggles
    step(1, 0, 0, 0, 8'h00, 1, 1, 0, "R6");
    step(1, 1, 1, 1, 8'hFF, 1, 1, 0, "R6");
    step(0, 0, 1, 0, 8'h00, 0, 0, 0, "R6");
    step(0, 1, 0, 0, 8'h00, 1, 0, 0, "R6");
    // R7 reset while in combinational mode clears register
    step(0, 1, 0, 0, 8'h80, 1, 0, 0, "R4");
    step(1, 0, 0, 0, 8'h00, 1, 0, 1, "R7");
    step(0, 1, 0, 0, 8'h00, 1, 0, 0, "R7");
    // R3 / R5: pt[0] alone enables but does not sum
    step(1, 1, 1, 0, 8'h01, 0, 1, 0, "R3");
    step(1, 1, 1, 1, 8'h01, 0, 0, 0, "R3");
    step(0, 1, 1, 0, 8'h01, 1, 1, 0, "R5");
    step(0, 1, 1, 0, 8'h02, 1, 0, 0, "R5");
    // R1 / R2 / R9: glob_oe and pin_in ignored where unused
    step(1, 0, 0, 0, 8'h00, 0, 1, 0, "R9");
    step(1, 0, 0, 1, 8'h00, 0, 1, 0, "R1");
    step(1, 0, 1, 0, 8'hFF, 1, 1, 0, "R9");
    step(1, 0, 1, 0, 8'hFF, 1, 0, 0, "R2");
    step(1, 1, 1, 0, 8'h00, 1, 0, 0, "R9");
    // R8 illegal codes
    step(0, 0, 0, 0, 8'hFF, 1, 1, 0, "R8");
    step(0, 0, 1, 1, 8'h00, 1, 1, 0, "R8");
    step(1, 1, 0, 0, 8'hFF, 1, 1, 0, "R8");
    // random mix over all codes
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] code;
      logic [N-1:0] p;
      code = 3'($urandom);
      p = ($urandom % 3 == 0) ? N'(1 << ($urandom % N)) : N'($urandom);
      if ($urandom % 4 == 0) p = '0;
      step(code[2], code[1], code[0], 1'($urandom), p, 1'($urandom), 1'($urandom),
           ($urandom % 50 == 0), "");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule